// File: doc/BRIEF.md
# Serial audio link frame receiver

This block sits on the codec side of a serial audio link and turns the controller's outbound bit stream into parallel words. A frame opens when the frame-sync line goes from low to high. It then runs for a fixed number of bit periods: one tag slot, followed by a row of data slots. The tag slot says whether the whole frame is usable and which of the four consumed data slots carry valid content. The receiver publishes these tag flags once per frame. It hands out a register command (read/write flag and register index), a register write word, and left and right PCM samples. Each of these outputs comes with a single-cycle strobe.

Both serial inputs are sampled on the falling edge of the bit clock, and all logic runs on that edge. A sync rise that lands inside a frame still in progress is treated as a fault. The rest of that frame is thrown away, and the receiver does not accept a new frame until the aborted frame's full length has run out. The register bank that consumes the command, any sample-rate conversion and all analog paths live outside this block.

Top module: `alink_frame_rx`

## Requirements
- R1: With no frame in progress, a sync rise starts a frame of FRAME_BITS = TAG_W + N_SLOTS*SLOT_W bit periods (256 with defaults). The bit sampled on the falling edge that first sees sync high is frame bit 0. A rise sampled on the bit right after the last bit of a frame starts the next frame back to back.
- R2: Bits arrive MSB first. Frame bits 0..TAG_W-1 form the tag slot, with bit 0 being tag bit TAG_W-1. Each data slot follows as SLOT_W bits, with its bit SLOT_W-1 first.
- R3: One cycle after the last tag bit, tag_stb_o pulses once. From then on, frame_vld_o holds tag bit 15 and slot_vld_o[0..3] hold tag bits 14, 13, 12 and 11 (slots 1..4).
- R4: Tag bits 10..0 have no effect on any output.
- R5: One cycle after the last bit of slot 1, cmd_stb_o pulses, provided slot_vld_o[0] is set. At that point cmd_rd_o takes slot bit 19 (1 = read) and cmd_addr_o takes slot bits 18:12.
- R6: One cycle after the last bit of slot 2, wr_stb_o pulses, provided slot_vld_o[1] is set. At that point wr_data_o takes slot bits 19:4.
- R7: One cycle after the last bit of slot 3 and slot 4 respectively, pcm_l_stb_o and pcm_r_stb_o pulse, provided slot_vld_o[2] or slot_vld_o[3] is set. The matching sample output takes slot bits 19:2.
- R8: A data output changes only while its strobe is high. When a slot's valid bit is clear, that slot produces no strobe and its outputs keep their previous values.
- R9: A sync rise sampled on frame bit 1..FRAME_BITS-1 aborts the frame. That bit and all later bits of the frame produce no strobe, and further rises before the aborted frame's length ends are ignored as well.
- R10: After an abort, the first sync rise sampled once the aborted frame's FRAME_BITS periods have passed is accepted as a new frame and decoded normally.
- R11: While reset is asserted, and after reset until the first decoded tag, every output is zero.
- R12: Each strobe is high for exactly one cycle per frame, and no two strobes are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Bit clock; all state changes on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync from the controller |
| sdo_i | input | 1 | Serial data from the controller |
| frame_vld_o | output | 1 | Frame-valid tag flag of the latest decoded tag |
| slot_vld_o | output | 4 | Valid flags for slots 1..4 |
| tag_stb_o | output | 1 | Pulse: tag slot decoded |
| cmd_stb_o | output | 1 | Pulse: valid command slot received |
| cmd_rd_o | output | 1 | Command direction, 1 = read |
| cmd_addr_o | output | ADDR_W | Register index |
| wr_stb_o | output | 1 | Pulse: valid write-data slot received |
| wr_data_o | output | WDATA_W | Register write data |
| pcm_l_stb_o | output | 1 | Pulse: valid left sample received |
| pcm_l_o | output | PCM_W | Left PCM sample |
| pcm_r_stb_o | output | 1 | Pulse: valid right sample received |
| pcm_r_o | output | PCM_W | Right PCM sample |

## Verification
The bench builds the block with N_SLOTS = 4, which gives 96-bit frames. Every consumed slot is still present in that configuration, and the unused data slots contribute nothing new. The short frame makes it cheap to sweep all 32 combinations of the five meaningful tag bits, each with a different filler pattern in the ignored tag bits. It also covers an early sync rise at every bit position from 2 to the frame's last bit, each followed by a correctly timed frame. Back-to-back frames and a second early rise inside an aborted window are also driven.

// File: rtl/alink_rx_pkg.sv
package alink_rx_pkg;

   // number of data slots the receiver consumes (command, write data, left, right)
   localparam int USED_SLOTS = 4;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,   // waiting for a sync rise
      FR_RUN  = 2'd1,   // frame being decoded
      FR_DROP = 2'd2    // frame aborted, counting out its window
   } fr_state_e;

   // frame bit index of the last bit of data slot s (s = 0 is slot 1)
   function automatic int slot_last(input int tag_w, input int slot_w, input int s);
      return tag_w + slot_w * (s + 1) - 1;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/alink_framer.sv
module alink_framer
   import alink_rx_pkg::*;
#(
   parameter int FRAME_BITS = 256,
   parameter int CNT_W      = 8
) (
   input  logic             bclk_i,
   input  logic             rst_ni,
   input  logic             sync_i,
   output logic             live_o,
   output logic [CNT_W-1:0] pos_o
);

   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

   logic             sync_q;
   logic             rise;
   fr_state_e        st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pos;

   assign rise = sync_i & ~sync_q;

   always_comb begin
      pos = (st_q == FR_IDLE) ? '0 : cnt_q + 1'b1;
      live_o = (st_q == FR_IDLE) ? rise : ((st_q == FR_RUN) && !rise);
      st_d = st_q;
      if (st_q == FR_IDLE) begin
         if (rise) st_d = FR_RUN;
      end else if (pos == LAST_POS) begin
         st_d = FR_IDLE;
      end else if (rise) begin
         st_d = FR_DROP;
      end
   end

   assign pos_o = pos;

   always_ff @(negedge bclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= 1'b0;
         st_q   <= FR_IDLE;
         cnt_q  <= '0;
      end else begin
         sync_q <= sync_i;
         st_q   <= st_d;
         cnt_q  <= pos;
      end
   end

endmodule

// File: rtl/alink_shifter.sv
module alink_shifter #(
   parameter int SLOT_W = 20,
   parameter int OUT_W  = 18
) (
   input  logic             bclk_i,
   input  logic             rst_ni,
   input  logic             sd_i,
   output logic [OUT_W-1:0] word_o
);

   logic [SLOT_W-2:0] sh_q;
   logic [SLOT_W-1:0] full;

   // the most recent SLOT_W bits, newest bit in position 0
   assign full   = {sh_q, sd_i};
   assign word_o = full[SLOT_W-1 -: OUT_W];

   always_ff @(negedge bclk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= full[SLOT_W-2:0];
   end

endmodule

// File: rtl/alink_tag_dec.sv
module alink_tag_dec #(
   parameter int TAG_W  = 16,
   parameter int N_USED = 4,
   parameter int CNT_W  = 8
) (
   input  logic              bclk_i,
   input  logic              rst_ni,
   input  logic              live_i,
   input  logic [CNT_W-1:0]  pos_i,
   input  logic [N_USED:0]   tag_i,
   output logic              tag_stb_o,
   output logic              frame_vld_o,
   output logic [N_USED-1:0] slot_vld_o
);

   logic hit;
   assign hit = live_i && (pos_i == CNT_W'(TAG_W - 1));

   always_ff @(negedge bclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tag_stb_o   <= 1'b0;
         frame_vld_o <= 1'b0;
      end else begin
         tag_stb_o <= hit;
         if (hit) frame_vld_o <= tag_i[N_USED];
      end
   end

   // slot s valid flag sits one place below the previous one (R3)
   for (genvar s = 0; s < N_USED; s++) begin : g_vld
      always_ff @(negedge bclk_i or negedge rst_ni) begin
         if (!rst_ni)  slot_vld_o[s] <= 1'b0;
         else if (hit) slot_vld_o[s] <= tag_i[N_USED-1-s];
      end
   end

endmodule

// File: rtl/alink_slot_cap.sv
module alink_slot_cap #(
   parameter int W        = 18,
   parameter int LAST_POS = 35,
   parameter int CNT_W    = 8
) (
   input  logic             bclk_i,
   input  logic             rst_ni,
   input  logic             live_i,
   input  logic [CNT_W-1:0] pos_i,
   input  logic             vld_i,
   input  logic [W-1:0]     word_i,
   output logic             stb_o,
   output logic [W-1:0]     data_o
);

   logic hit;
   assign hit = live_i && vld_i && (pos_i == CNT_W'(LAST_POS));

   always_ff @(negedge bclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stb_o  <= 1'b0;
         data_o <= '0;
      end else begin
         stb_o <= hit;
         if (hit) data_o <= word_i;
      end
   end

endmodule

// File: rtl/alink_frame_rx.sv
module alink_frame_rx
   import alink_rx_pkg::*;
#(
   parameter int TAG_W   = 16,
   parameter int SLOT_W  = 20,
   parameter int N_SLOTS = 12,
   parameter int ADDR_W  = 7,
   parameter int WDATA_W = 16,
   parameter int PCM_W   = 18
) (
   input  logic                  bclk_i,
   input  logic                  rst_ni,
   input  logic                  sync_i,
   input  logic                  sdo_i,
   output logic                  frame_vld_o,
   output logic [USED_SLOTS-1:0] slot_vld_o,
   output logic                  tag_stb_o,
   output logic                  cmd_stb_o,
   output logic                  cmd_rd_o,
   output logic [ADDR_W-1:0]     cmd_addr_o,
   output logic                  wr_stb_o,
   output logic [WDATA_W-1:0]    wr_data_o,
   output logic                  pcm_l_stb_o,
   output logic [PCM_W-1:0]      pcm_l_o,
   output logic                  pcm_r_stb_o,
   output logic [PCM_W-1:0]      pcm_r_o
);

   localparam int FRAME_BITS = TAG_W + N_SLOTS * SLOT_W;
   localparam int CNT_W      = $clog2(FRAME_BITS);
   localparam int CMD_W      = 1 + ADDR_W;
   localparam int TAG_SPAN   = SLOT_W - (TAG_W - USED_SLOTS - 1);
   localparam int OUT_W      = max2(max2(CMD_W, WDATA_W), max2(PCM_W, TAG_SPAN));
   localparam int TAG_TOP    = TAG_W - 1 - (SLOT_W - OUT_W);

   // elaboration-time parameter checks
   if (TAG_W < USED_SLOTS + 1) begin : g_err_tag
      $error("TAG_W too small for the used tag flags");
   end
   if (TAG_W > SLOT_W) begin : g_err_tagw
      $error("TAG_W must not exceed SLOT_W");
   end
   if (N_SLOTS < USED_SLOTS) begin : g_err_slots
      $error("N_SLOTS must cover the consumed slots");
   end
   if (CMD_W > SLOT_W || WDATA_W > SLOT_W || PCM_W > SLOT_W) begin : g_err_fld
      $error("field wider than a slot");
   end

   logic             live;
   logic [CNT_W-1:0] pos;
   logic [OUT_W-1:0] word;
   logic [CMD_W-1:0] cmd_word;

   alink_framer #(
      .FRAME_BITS (FRAME_BITS),
      .CNT_W      (CNT_W)
   ) framer_i (
      .bclk_i (bclk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_i),
      .live_o (live),
      .pos_o  (pos)
   );

   alink_shifter #(
      .SLOT_W (SLOT_W),
      .OUT_W  (OUT_W)
   ) shifter_i (
      .bclk_i (bclk_i),
      .rst_ni (rst_ni),
      .sd_i   (sdo_i),
      .word_o (word)
   );

   alink_tag_dec #(
      .TAG_W  (TAG_W),
      .N_USED (USED_SLOTS),
      .CNT_W  (CNT_W)
   ) tag_i (
      .bclk_i      (bclk_i),
      .rst_ni      (rst_ni),
      .live_i      (live),
      .pos_i       (pos),
      .tag_i       (word[TAG_TOP -: USED_SLOTS+1]),
      .tag_stb_o   (tag_stb_o),
      .frame_vld_o (frame_vld_o),
      .slot_vld_o  (slot_vld_o)
   );

   // one capture stage per consumed slot; the field width picks the variant
   for (genvar s = 0; s < USED_SLOTS; s++) begin : g_slot
      localparam int LAST_POS = slot_last(TAG_W, SLOT_W, s);
      if (s == 0) begin : g_cmd
         alink_slot_cap #(.W(CMD_W), .LAST_POS(LAST_POS), .CNT_W(CNT_W)) cap_i (
            .bclk_i (bclk_i), .rst_ni (rst_ni), .live_i (live), .pos_i (pos),
            .vld_i  (slot_vld_o[s]), .word_i (word[OUT_W-1 -: CMD_W]),
            .stb_o  (cmd_stb_o), .data_o (cmd_word));
      end else if (s == 1) begin : g_wr
         alink_slot_cap #(.W(WDATA_W), .LAST_POS(LAST_POS), .CNT_W(CNT_W)) cap_i (
            .bclk_i (bclk_i), .rst_ni (rst_ni), .live_i (live), .pos_i (pos),
            .vld_i  (slot_vld_o[s]), .word_i (word[OUT_W-1 -: WDATA_W]),
            .stb_o  (wr_stb_o), .data_o (wr_data_o));
      end else if (s == 2) begin : g_left
         alink_slot_cap #(.W(PCM_W), .LAST_POS(LAST_POS), .CNT_W(CNT_W)) cap_i (
            .bclk_i (bclk_i), .rst_ni (rst_ni), .live_i (live), .pos_i (pos),
            .vld_i  (slot_vld_o[s]), .word_i (word[OUT_W-1 -: PCM_W]),
            .stb_o  (pcm_l_stb_o), .data_o (pcm_l_o));
      end else begin : g_right
         alink_slot_cap #(.W(PCM_W), .LAST_POS(LAST_POS), .CNT_W(CNT_W)) cap_i (
            .bclk_i (bclk_i), .rst_ni (rst_ni), .live_i (live), .pos_i (pos),
            .vld_i  (slot_vld_o[s]), .word_i (word[OUT_W-1 -: PCM_W]),
            .stb_o  (pcm_r_stb_o), .data_o (pcm_r_o));
      end
   end

   // R5: direction flag on top, register index right below it
   assign cmd_rd_o   = cmd_word[CMD_W-1];
   assign cmd_addr_o = cmd_word[ADDR_W-1:0];

endmodule

// File: rtl/alink_frame_rx_chk.sv
module alink_frame_rx_chk #(
   parameter int TAG_W   = 16,
   parameter int SLOT_W  = 20,
   parameter int N_SLOTS = 12,
   parameter int ADDR_W  = 7,
   parameter int WDATA_W = 16,
   parameter int PCM_W   = 18
) (
   input logic               bclk_i,
   input logic               rst_ni,
   input logic               frame_vld_o,
   input logic [3:0]         slot_vld_o,
   input logic               tag_stb_o,
   input logic               cmd_stb_o,
   input logic               cmd_rd_o,
   input logic [ADDR_W-1:0]  cmd_addr_o,
   input logic               wr_stb_o,
   input logic [WDATA_W-1:0] wr_data_o,
   input logic               pcm_l_stb_o,
   input logic [PCM_W-1:0]   pcm_l_o,
   input logic               pcm_r_stb_o,
   input logic [PCM_W-1:0]   pcm_r_o
);

   localparam int FRAME_BITS = TAG_W + N_SLOTS * SLOT_W;
   localparam int CNT_W      = $clog2(FRAME_BITS);

   logic [4:0]     stbs;
   logic [CNT_W:0] since_q;

   assign stbs = {tag_stb_o, cmd_stb_o, wr_stb_o, pcm_l_stb_o, pcm_r_stb_o};

   always_ff @(negedge bclk_i or negedge rst_ni) begin
      if (!rst_ni)                                  since_q <= (CNT_W+1)'(FRAME_BITS);
      else if (tag_stb_o)                           since_q <= '0;
      else if (since_q < (CNT_W+1)'(FRAME_BITS))    since_q <= since_q + 1'b1;
   end

   // R12
   strobe_excl_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      $onehot0(stbs));

   // R12
   strobe_single_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      (|stbs) |=> !(|stbs));

   // R1
   tag_spacing_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      tag_stb_o |-> (since_q >= (CNT_W+1)'(FRAME_BITS - 1)));

   // R3
   tag_hold_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      !$stable({frame_vld_o, slot_vld_o}) |-> tag_stb_o);

   // R5
   cmd_gate_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      cmd_stb_o |-> slot_vld_o[0]);

   // R6
   wr_gate_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      wr_stb_o |-> slot_vld_o[1]);

   // R7
   pcm_gate_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      (pcm_l_stb_o |-> slot_vld_o[2]) and (pcm_r_stb_o |-> slot_vld_o[3]));

   // R8
   cmd_hold_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      !$stable({cmd_rd_o, cmd_addr_o}) |-> cmd_stb_o);

   // R8
   wr_hold_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      !$stable(wr_data_o) |-> wr_stb_o);

   // R8
   pcm_hold_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
      (!$stable(pcm_l_o) |-> pcm_l_stb_o) and (!$stable(pcm_r_o) |-> pcm_r_stb_o));

endmodule

bind alink_frame_rx alink_frame_rx_chk #(
   .TAG_W   (TAG_W),
   .SLOT_W  (SLOT_W),
   .N_SLOTS (N_SLOTS),
   .ADDR_W  (ADDR_W),
   .WDATA_W (WDATA_W),
   .PCM_W   (PCM_W)
) chk_i (
   .bclk_i      (bclk_i),
   .rst_ni      (rst_ni),
   .frame_vld_o (frame_vld_o),
   .slot_vld_o  (slot_vld_o),
   .tag_stb_o   (tag_stb_o),
   .cmd_stb_o   (cmd_stb_o),
   .cmd_rd_o    (cmd_rd_o),
   .cmd_addr_o  (cmd_addr_o),
   .wr_stb_o    (wr_stb_o),
   .wr_data_o   (wr_data_o),
   .pcm_l_stb_o (pcm_l_stb_o),
   .pcm_l_o     (pcm_l_o),
   .pcm_r_stb_o (pcm_r_stb_o),
   .pcm_r_o     (pcm_r_o)
);

// File: tb/alink_frame_rx_tb_top.sv
module alink_frame_rx_tb_top;

   localparam int NS    = 4;
   localparam int FRAME = 16 + NS * 20;

   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync = 1'b0;
   logic        sdo = 1'b0;
   logic        fv, tstb, cstb, crd, wstb, lstb, rstb;
   logic [3:0]  sv;
   logic [6:0]  caddr;
   logic [15:0] wdat;
   logic [17:0] pl, pr;

   int checks = 0;
   int errors = 0;
   int n_tag = 0, n_cmd = 0, n_wr = 0, n_l = 0, n_r = 0;

   logic [15:0] tg;
   logic [19:0] wd [4];

   logic        e_fv = 0, e_rd = 0;
   logic [3:0]  e_sv = 0;
   logic [6:0]  e_addr = 0;
   logic [15:0] e_wr = 0;
   logic [17:0] e_l = 0, e_r = 0;

   always #4 bclk = ~bclk;

   alink_frame_rx #(.N_SLOTS(NS)) dut_i (
      .bclk_i (bclk), .rst_ni (rst_n), .sync_i (sync), .sdo_i (sdo),
      .frame_vld_o (fv), .slot_vld_o (sv), .tag_stb_o (tstb),
      .cmd_stb_o (cstb), .cmd_rd_o (crd), .cmd_addr_o (caddr),
      .wr_stb_o (wstb), .wr_data_o (wdat),
      .pcm_l_stb_o (lstb), .pcm_l_o (pl), .pcm_r_stb_o (rstb), .pcm_r_o (pr));

   // strobe counters, sampled away from the active (falling) edge
   always @(posedge bclk) begin
      if (rst_n) begin
         if (tstb) n_tag++;
         if (cstb) n_cmd++;
         if (wstb) n_wr++;
         if (lstb) n_l++;
         if (rstb) n_r++;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   function automatic logic bit_at(input int b);
      if (b < 16) return tg[15-b];
      return wd[(b-16)/20][19-((b-16)%20)];
   endfunction

   function automatic logic [19:0] mkw(input int k, input int s);
      return 20'(k * 200003 + s * 99991 + 777);
   endfunction

   task automatic clr();
      n_tag = 0; n_cmd = 0; n_wr = 0; n_l = 0; n_r = 0;
   endtask

   task automatic send(input int early1, input int early2, input int gap);
      for (int b = 0; b < FRAME; b++) begin
         @(posedge bclk);
         sync = (b == 0) || (b == early1) || (b == early2);
         sdo  = bit_at(b);
      end
      for (int g = 0; g < gap; g++) begin
         @(posedge bclk);
         sync = 1'b0;
         sdo  = 1'b0;
      end
   endtask

   // expected results from the requirements; lim = first discarded bit
   task automatic check_frame(input int lim);
      bit f_tag, f_c, f_w, f_l, f_r;
      #2;
      f_tag = (15 < lim);
      if (f_tag) begin
         e_fv = tg[15];
         e_sv = {tg[11], tg[12], tg[13], tg[14]};
      end
      f_c = f_tag && (35 < lim) && e_sv[0];
      f_w = f_tag && (55 < lim) && e_sv[1];
      f_l = f_tag && (75 < lim) && e_sv[2];
      f_r = f_tag && (95 < lim) && e_sv[3];
      if (f_c) begin e_rd = wd[0][19]; e_addr = wd[0][18:12]; end
      if (f_w) e_wr = wd[1][19:4];
      if (f_l) e_l = wd[2][19:2];
      if (f_r) e_r = wd[3][19:2];
      chk("R3 R9 R12 tag strobe count", n_tag, f_tag);
      chk("R3 R2 frame valid", fv, e_fv);
      chk("R3 R4 slot valid", sv, e_sv);
      chk("R5 R8 R12 command strobe count", n_cmd, f_c);
      chk("R5 R2 command read flag", crd, e_rd);
      chk("R5 R8 command index", caddr, e_addr);
      chk("R6 R8 write strobe count", n_wr, f_w);
      chk("R6 write data", wdat, e_wr);
      chk("R7 R8 left strobe count", n_l, f_l);
      chk("R7 left sample", pl, e_l);
      chk("R7 R8 right strobe count", n_r, f_r);
      chk("R7 right sample", pr, e_r);
   endtask

   task automatic load(input logic [15:0] t, input int k);
      tg = t;
      for (int s = 0; s < 4; s++) wd[s] = mkw(k, s);
   endtask

   initial begin
      repeat (3) @(posedge bclk);
      #2;
      // R11: reset values
      chk("R11 reset frame valid", fv, 0);
      chk("R11 reset slot valid", sv, 0);
      chk("R11 reset strobes", {tstb, cstb, wstb, lstb, rstb}, 0);
      chk("R11 reset data", {crd, caddr, wdat}, 0);
      chk("R11 reset samples", {pl, pr}, 0);
      @(posedge bclk);
      rst_n = 1'b1;
      repeat (3) @(posedge bclk);
      #2;
      chk("R11 idle after reset", {fv, sv, pl, pr, wdat}, 0);

      // R3 R4 R5 R6 R7 R8: every combination of the five meaningful tag bits
      for (int k = 0; k < 32; k++) begin
         load({5'(k), 11'((k * 677) ^ 11'h5A5)}, k);
         clr();
         send(-1, -1, 2);
         check_frame(FRAME);
      end

      // R4: only the ignored tag bits differ between two frames
      load(16'hA800, 40);
      clr(); send(-1, -1, 2); check_frame(FRAME);
      load(16'hAFFF, 41);
      clr(); send(-1, -1, 2); check_frame(FRAME);

      // R1: back-to-back frames, second rise one bit after the last bit
      load(16'hF800, 50);
      clr();
      send(-1, -1, 0);
      load(16'hF800, 51);
      send(-1, -1, 2);
      #2;
      chk("R1 back-to-back tag count", n_tag, 2);
      chk("R1 back-to-back right count", n_r, 2);
      chk("R1 second frame left sample", pl, wd[2][19:2]);
      chk("R1 second frame write data", wdat, wd[1][19:4]);
      e_fv = 1; e_sv = 4'hF;
      e_rd = wd[0][19]; e_addr = wd[0][18:12]; e_wr = wd[1][19:4];
      e_l = wd[2][19:2]; e_r = wd[3][19:2];

      // R9 R10: early rise at every position, then a properly timed frame
      for (int a = 2; a < FRAME; a++) begin
         load(16'hF800, 100 + a);
         clr(); send(a, -1, 2); check_frame(a);
         load(16'hF800, 300 + a);
         clr(); send(-1, -1, 2); check_frame(FRAME);
      end

      // R9: a second early rise inside the aborted window is also ignored
      load(16'hF800, 600);
      clr(); send(20, 50, 2); check_frame(20);
      load(16'hF800, 601);
      clr(); send(-1, -1, 2); check_frame(FRAME);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge bclk);
      checks++;
      errors++;
      $display("FAIL watchdog expired, act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule